// File: doc/BRIEF.md
# Block Gap Stop/Continue Controller

This block sequences pauses in a multi-block data transfer of a memory-card host. Software can ask it to halt at the next boundary between two blocks and later release it. It never cuts into a block that is still moving. A two-bit control register on a small register bus holds a stop-request bit and a continue-request bit. The sequencer counts block-end strobes against the block count it loaded at start. It holds a paused read in one of two ways: it drives the read-wait level on data line 2, or it stops the card clock through an enable that changes only while the clock is low. During a paused write it raises a hold-off flag so that no further data is supplied.

The state machine has five states. IDLE moves to RUNNING on a start strobe, which loads the block count and latches the direction. RUNNING moves to STOP_PENDING when the stop bit is seen set. A block end while the stop bit is set moves RUNNING straight to PAUSED. A block end in STOP_PENDING moves to PAUSED, unless it ends the final block; in that case both RUNNING and STOP_PENDING return to IDLE. PAUSED moves to RESUMING when the continue bit is set with the stop bit clear. RESUMING moves to RUNNING after exactly one cycle. A one-cycle done pulse marks every entry into PAUSED and every completion of the final block.

Top module: `bgap_ctrl`

## Requirements
- R1: While the stop bit is 1 and no block end arrives, the transfer keeps running: the direction's active flag and data-line-active stay 1. The pause begins only on the clock edge that samples a block-end strobe.
- R2: While the stored stop bit (read data bit 0) is 1, a register write cannot set the continue bit (read data bit 1), whatever the write data holds.
- R3: A write of 0 to both bits during a pause leaves the transfer paused. Writing continue = 1 with the stop bit 0 resumes it: the active flags are 1 two cycles after that write's edge, with one RESUMING cycle between.
- R4: The continue bit clears itself one cycle after the restart edge of its matching active flag. That flag is data-line-active for a read and write-active for a write.
- R5: A paused read with read-wait support (rdwait_cap = 1) drives dat2_read_wait to 1 and keeps the card clock running. The read-wait level returns to 0 when the resume begins.
- R6: A paused read without read-wait support gates the card clock. card_clk_en falls at the next falling clock edge after the pause begins, and card_clk is then held low. The enable returns at the first falling edge after the resume begins.
- R7: On entry to PAUSED, xfer_done pulses for one cycle. In the same cycle rd_active, wr_active, dat_active and dat_cmd_inhibit go to 0.
- R8: A stop requested during the final block lets that block finish. The controller returns to IDLE with a done pulse, and no pause takes place.
- R9: After reset both control bits read 0, all status flags are 0, read-wait is 0 and the card clock is enabled.
- R10: A transfer of N blocks with no stop keeps its direction flag, dat_active and dat_cmd_inhibit at 1. On the N-th block end it drops them and pulses xfer_done.
- R11: For a write, wr_hold is 1 in STOP_PENDING and PAUSED, and 0 while the transfer is running normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 2 | Write data: bit 0 stop request, bit 1 continue request |
| reg_rdata | output | 2 | Read data in the same bit layout |
| xfer_start | input | 1 | Start strobe for a new multi-block transfer |
| xfer_is_read | input | 1 | Direction at start: 1 read, 0 write |
| xfer_blocks | input | BLK_W | Number of blocks in the transfer |
| block_end | input | 1 | One-cycle strobe at the end of each block |
| rdwait_cap | input | 1 | Card supports read-wait signalling |
| card_clk | output | 1 | Gated card clock |
| card_clk_en | output | 1 | Glitch-free card clock enable |
| dat2_read_wait | output | 1 | Read-wait level for data line 2 |
| rd_active | output | 1 | Read transfer active |
| wr_active | output | 1 | Write transfer active |
| dat_active | output | 1 | Data line active |
| dat_cmd_inhibit | output | 1 | Data command inhibit |
| xfer_done | output | 1 | One-cycle transfer-complete pulse |
| wr_hold | output | 1 | Write data hold-off |

## Verification
A wrong state shows up at the status flags one edge after it is entered, because every flag is decoded from the state register. An early or missing pause therefore appears as an active flag that falls on the wrong edge. A lost or stuck continue bit shows in the register read data. It either stays 1 past the cycle after the restart edge or turns on while the stop bit is set. A wrong clock-gate decision shows at card_clk_en half a cycle later, at the falling edge, and shows on card_clk during the next high phase.

// File: rtl/bgap_pkg.sv
package bgap_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RUNNING,
        S_STOP_PENDING,
        S_PAUSED,
        S_RESUMING
    } bgap_state_e;

    localparam int CTL_BITS  = 2;
    localparam int BIT_STOP  = 0;
    localparam int BIT_CONT  = 1;

endpackage

// File: rtl/bgap_ctlreg.sv
module bgap_ctlreg
    import bgap_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CTL_BITS-1:0] wdata,
    input  logic                dir_rd,
    input  logic                line_act,
    input  logic                wr_act,
    output logic                stop_q,
    output logic                cont_q,
    output logic [CTL_BITS-1:0] rdata
);

    logic watch_flag;
    logic watch_prev;
    logic restart_edge;
    logic cont_set;

    // Restart edge of the active flag that matches the latched direction
    assign watch_flag   = dir_rd ? line_act : wr_act;
    assign restart_edge = watch_flag & ~watch_prev;
    assign cont_set     = wr_en & ~stop_q & wdata[BIT_CONT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stop_q     <= 1'b0;
            cont_q     <= 1'b0;
            watch_prev <= 1'b0;
        end else begin
            watch_prev <= watch_flag;
            if (wr_en) begin
                stop_q <= wdata[BIT_STOP];
            end
            if (cont_set) begin
                cont_q <= 1'b1;
            end else if (restart_edge) begin
                cont_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata           = '0;
        rdata[BIT_STOP] = stop_q;
        rdata[BIT_CONT] = cont_q;
    end

    // R2: a write never sets continue while stop is held
    assert_cont_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && stop_q && !cont_q) |=> !cont_q);

endmodule

// File: rtl/bgap_seq.sv
module bgap_seq
    import bgap_pkg::*;
#(
    parameter int BLK_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_rd,
    input  logic [BLK_W-1:0] blk_total,
    input  logic             blk_end,
    input  logic             stop_req,
    input  logic             cont_req,
    input  logic             rdwait_ok,
    output logic             dir_rd,
    output logic             rd_active,
    output logic             wr_active,
    output logic             dat_active,
    output logic             dat_inhibit,
    output logic             xfer_done,
    output logic             read_wait,
    output logic             gate_req,
    output logic             wr_hold
);

    localparam logic [BLK_W-1:0] ONE_BLK = BLK_W'(1);

    bgap_state_e       state, state_nx;
    logic [BLK_W-1:0]  remaining, remaining_nx;
    logic              dir_nx;
    logic              done_nx;
    logic              last_blk;
    logic              moving;

    assign last_blk = (remaining <= ONE_BLK);

    // Next-state decision
    always_comb begin
        state_nx     = state;
        remaining_nx = remaining;
        dir_nx       = dir_rd;
        done_nx      = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    state_nx     = S_RUNNING;
                    remaining_nx = blk_total;
                    dir_nx       = start_rd;
                end
            end
            S_RUNNING: begin
                if (blk_end) begin
                    remaining_nx = remaining - ONE_BLK;
                    if (last_blk) begin
                        state_nx = S_IDLE;
                        done_nx  = 1'b1;
                    end else if (stop_req) begin
                        state_nx = S_PAUSED;
                        done_nx  = 1'b1;
                    end
                end else if (stop_req) begin
                    state_nx = S_STOP_PENDING;
                end
            end
            S_STOP_PENDING: begin
                if (blk_end) begin
                    remaining_nx = remaining - ONE_BLK;
                    state_nx     = last_blk ? S_IDLE : S_PAUSED;
                    done_nx      = 1'b1;
                end
            end
            S_PAUSED: begin
                if (cont_req && !stop_req) begin
                    state_nx = S_RESUMING;
                end
            end
            S_RESUMING: begin
                state_nx = S_RUNNING;
            end
            default: begin
                state_nx = S_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            remaining <= '0;
            dir_rd    <= 1'b0;
            xfer_done <= 1'b0;
        end else begin
            state     <= state_nx;
            remaining <= remaining_nx;
            dir_rd    <= dir_nx;
            xfer_done <= done_nx;
        end
    end

    // Outputs decoded from state
    always_comb begin
        moving      = 1'b0;
        dat_inhibit = 1'b0;
        read_wait   = 1'b0;
        gate_req    = 1'b0;
        wr_hold     = 1'b0;
        unique case (state)
            S_IDLE: begin
            end
            S_RUNNING: begin
                moving      = 1'b1;
                dat_inhibit = 1'b1;
            end
            S_STOP_PENDING: begin
                moving      = 1'b1;
                dat_inhibit = 1'b1;
                wr_hold     = ~dir_rd;
            end
            S_PAUSED: begin
                read_wait = dir_rd & rdwait_ok;
                gate_req  = dir_rd & ~rdwait_ok;
                wr_hold   = ~dir_rd;
            end
            S_RESUMING: begin
                dat_inhibit = 1'b1;
            end
            default: begin
            end
        endcase
        rd_active  = moving & dir_rd;
        wr_active  = moving & ~dir_rd;
        dat_active = moving;
    end

    // R1: no pause without a block end
    assert_gap_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STOP_PENDING && !blk_end) |=> (state != S_PAUSED));

    // R7: pause entry gives a done pulse and idle flags
    assert_pause_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STOP_PENDING && blk_end && !last_blk)
            |=> (xfer_done && !dat_active && !dat_inhibit));

    // R8: final block returns to idle
    assert_last_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && state != S_PAUSED && state != S_RESUMING && blk_end && last_blk)
            |=> (state == S_IDLE && xfer_done));

    // R3: no restart without an accepted continue
    assert_hold_pause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PAUSED && !cont_req) |=> (state == S_PAUSED));

    // R5: read-wait and clock gating are exclusive
    assert_hold_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        read_wait |-> (!gate_req && !dat_active));

endmodule

// File: rtl/bgap_clkgate.sv
module bgap_clkgate (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_req,
    output logic clk_en,
    output logic card_clk
);

    // Enable moves only on the falling edge, so the AND sees no glitch
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_en <= 1'b1;
        end else begin
            clk_en <= ~gate_req;
        end
    end

    assign card_clk = clk & clk_en;

    // R6: settled request is reflected by the enable
    assert_gate_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_req && $past(gate_req)) |-> !clk_en);

    assert_gate_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_req && !$past(gate_req)) |-> clk_en);

endmodule

// File: rtl/bgap_ctrl.sv
module bgap_ctrl
    import bgap_pkg::*;
#(
    parameter int BLK_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_wdata,
    output logic [1:0]       reg_rdata,
    input  logic             xfer_start,
    input  logic             xfer_is_read,
    input  logic [BLK_W-1:0] xfer_blocks,
    input  logic             block_end,
    input  logic             rdwait_cap,
    output logic             card_clk,
    output logic             card_clk_en,
    output logic             dat2_read_wait,
    output logic             rd_active,
    output logic             wr_active,
    output logic             dat_active,
    output logic             dat_cmd_inhibit,
    output logic             xfer_done,
    output logic             wr_hold
);

    logic stop_q;
    logic cont_q;
    logic dir_rd;
    logic gate_req;

    bgap_ctlreg u_ctlreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .wdata    (reg_wdata),
        .dir_rd   (dir_rd),
        .line_act (dat_active),
        .wr_act   (wr_active),
        .stop_q   (stop_q),
        .cont_q   (cont_q),
        .rdata    (reg_rdata)
    );

    bgap_seq #(
        .BLK_W (BLK_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (xfer_start),
        .start_rd    (xfer_is_read),
        .blk_total   (xfer_blocks),
        .blk_end     (block_end),
        .stop_req    (stop_q),
        .cont_req    (cont_q),
        .rdwait_ok   (rdwait_cap),
        .dir_rd      (dir_rd),
        .rd_active   (rd_active),
        .wr_active   (wr_active),
        .dat_active  (dat_active),
        .dat_inhibit (dat_cmd_inhibit),
        .xfer_done   (xfer_done),
        .read_wait   (dat2_read_wait),
        .gate_req    (gate_req),
        .wr_hold     (wr_hold)
    );

    bgap_clkgate u_clkgate (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate_req (gate_req),
        .clk_en   (card_clk_en),
        .card_clk (card_clk)
    );

endmodule

// File: tb/bgap_ctrl_test.sv
module bgap_ctrl_test;

    localparam int BLK_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic [1:0]       reg_wdata = 2'b00;
    logic [1:0]       reg_rdata;
    logic             xfer_start = 1'b0;
    logic             xfer_is_read = 1'b0;
    logic [BLK_W-1:0] xfer_blocks = '0;
    logic             block_end = 1'b0;
    logic             rdwait_cap = 1'b0;
    logic             card_clk, card_clk_en, dat2_read_wait;
    logic             rd_active, wr_active, dat_active, dat_cmd_inhibit;
    logic             xfer_done, wr_hold;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    bgap_ctrl #(.BLK_W(BLK_W)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .xfer_start(xfer_start), .xfer_is_read(xfer_is_read),
        .xfer_blocks(xfer_blocks), .block_end(block_end), .rdwait_cap(rdwait_cap),
        .card_clk(card_clk), .card_clk_en(card_clk_en), .dat2_read_wait(dat2_read_wait),
        .rd_active(rd_active), .wr_active(wr_active), .dat_active(dat_active),
        .dat_cmd_inhibit(dat_cmd_inhibit), .xfer_done(xfer_done), .wr_hold(wr_hold)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic reg_write(input logic [1:0] d);
        reg_wr = 1'b1;
        reg_wdata = d;
        tick();
        reg_wr = 1'b0;
        reg_wdata = 2'b00;
    endtask

    task automatic start_xfer(input logic rd, input int n);
        xfer_start = 1'b1;
        xfer_is_read = rd;
        xfer_blocks = BLK_W'(n);
        tick();
        xfer_start = 1'b0;
    endtask

    task automatic end_block();
        block_end = 1'b1;
        tick();
        block_end = 1'b0;
    endtask

    task automatic test_reset();
        check("R9 rdata", {6'd0, reg_rdata}, 8'h00);
        check("R9 flags", {4'd0, rd_active, wr_active, dat_active, dat_cmd_inhibit}, 8'h00);
        check("R9 done/hold", {6'd0, xfer_done, wr_hold}, 8'h00);
        check("R9 clk_en", {7'd0, card_clk_en}, 8'h01);
        check("R9 read_wait", {7'd0, dat2_read_wait}, 8'h00);
    endtask

    task automatic test_plain_read();
        start_xfer(1'b1, 3);
        check("R10 run flags", {4'd0, rd_active, wr_active, dat_active, dat_cmd_inhibit}, 8'h0B);
        end_block();
        end_block();
        check("R10 mid flags", {4'd0, rd_active, wr_active, dat_active, xfer_done}, 8'h0A);
        end_block();
        check("R10 end flags", {4'd0, rd_active, dat_active, dat_cmd_inhibit, xfer_done}, 8'h01);
        tick();
        check("R10 done pulse one cycle", {7'd0, xfer_done}, 8'h00);
    endtask

    task automatic test_write_pause();
        start_xfer(1'b0, 4);
        check("R11 hold while running", {7'd0, wr_hold}, 8'h00);
        reg_write(2'b01);
        check("R2 stop readback", {6'd0, reg_rdata}, 8'h01);
        tick();
        tick();
        tick();
        check("R1 still running", {6'd0, wr_active, dat_active}, 8'h03);
        check("R11 hold when pending", {7'd0, wr_hold}, 8'h01);
        end_block();
        check("R7 pause entry", {3'd0, xfer_done, rd_active, wr_active, dat_active, dat_cmd_inhibit}, 8'h10);
        check("R11 hold when paused", {7'd0, wr_hold}, 8'h01);
        tick();
        check("R7 done one cycle", {7'd0, xfer_done}, 8'h00);
        reg_write(2'b11);
        check("R2 continue ignored", {6'd0, reg_rdata}, 8'h01);
        reg_write(2'b00);
        tick();
        tick();
        tick();
        check("R3 both clear stays paused", {6'd0, wr_active, dat_active}, 8'h00);
        reg_write(2'b10);
        check("R3 continue set", {6'd0, reg_rdata}, 8'h02);
        tick();
        check("R3 resuming cycle", {6'd0, wr_active, dat_cmd_inhibit}, 8'h01);
        tick();
        check("R3 running again", {6'd0, wr_active, dat_active}, 8'h03);
        check("R4 continue still set", {6'd0, reg_rdata}, 8'h02);
        tick();
        check("R4 write continue cleared", {6'd0, reg_rdata}, 8'h00);
        end_block();
        end_block();
        end_block();
        check("R10 write finish", {6'd0, wr_active, xfer_done}, 8'h01);
        tick();
    endtask

    task automatic test_read_pause(input logic rw_ok);
        rdwait_cap = rw_ok;
        start_xfer(1'b1, 3);
        reg_write(2'b01);
        tick();
        end_block();
        check("R7 read pause flags", {5'd0, rd_active, dat_active, xfer_done}, 8'h01);
        if (rw_ok) begin
            check("R5 read wait on", {7'd0, dat2_read_wait}, 8'h01);
            #10;
            check("R5 clock kept", {7'd0, card_clk_en}, 8'h01);
        end else begin
            check("R6 enable before fall", {7'd0, card_clk_en}, 8'h01);
            check("R6 no read wait", {7'd0, dat2_read_wait}, 8'h00);
            #10;
            check("R6 enable off", {7'd0, card_clk_en}, 8'h00);
            tick();
            check("R6 card clock low", {7'd0, card_clk}, 8'h00);
        end
        reg_write(2'b00);
        reg_write(2'b10);
        tick();
        if (rw_ok) begin
            check("R5 read wait off", {7'd0, dat2_read_wait}, 8'h00);
        end else begin
            check("R6 enable still off", {7'd0, card_clk_en}, 8'h00);
            #10;
            check("R6 enable back", {7'd0, card_clk_en}, 8'h01);
        end
        tick();
        check("R4 read line active", {6'd0, rd_active, dat_active}, 8'h03);
        tick();
        check("R4 read continue cleared", {6'd0, reg_rdata}, 8'h00);
        end_block();
        end_block();
        check("R10 read finish", {6'd0, rd_active, xfer_done}, 8'h01);
        tick();
        rdwait_cap = 1'b0;
    endtask

    task automatic test_last_block_stop();
        start_xfer(1'b0, 2);
        end_block();
        reg_write(2'b01);
        tick();
        end_block();
        check("R8 idle done", {4'd0, wr_active, dat_cmd_inhibit, wr_hold, xfer_done}, 8'h01);
        tick();
        check("R8 no pause", {5'd0, wr_hold, dat_cmd_inhibit, xfer_done}, 8'h00);
        reg_write(2'b00);
    endtask

    initial begin
        #25;
        rst_n = 1'b1;
        #4;
        test_reset();
        test_plain_read();
        test_write_pause();
        test_read_pause(1'b1);
        test_read_pause(1'b0);
        test_last_block_stop();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule